// File: doc/BRIEF.md
# Packed 52-bit multiply-accumulate unit

This block is a SIMD datapath over a vector of 64-bit lanes; a parameter sets two, four or eight lanes. For each lane it takes the low 52 bits of two multiplicand operands and multiplies them as unsigned numbers into a 104-bit product. It then adds one 52-bit half of that product to the 64-bit accumulator lane: the upper half for a "high" operation, the lower half for a "low" operation. Used as a pair, the two operations build wide-integer arithmetic from 52-bit limbs.

A per-lane write mask selects each lane's result. A set bit gives the computed sum. A clear bit gives either the accumulator lane unchanged (merge mode) or zero (zeroing mode). Operations enter with a valid strobe, one per cycle at most, and their results leave a fixed two cycles later. The operation kind, mask mode and mask travel through the pipeline with their data.

Top module: `pmac_unit`

## Requirements
- R1: With `in_hi` = 1, each selected lane returns acc + (product bits [103:52], zero-extended), where product = B[51:0] * C[51:0] unsigned; for acc = 10<<40, B = (11<<40)+4, C = (12<<40)+3 the lane value is 11030549757952.
- R2: With `in_hi` = 0, each selected lane returns acc + (product bits [51:0], zero-extended); for the same operands the lane value is 100055558127628.
- R3: Bits [63:52] of each B and C lane have no effect on the result.
- R4: The 64-bit addition wraps modulo 2^64 with no carry out of the lane.
- R5: With `in_zero` = 0 (merge), a lane whose mask bit is 0 returns its accumulator lane unchanged.
- R6: With `in_zero` = 1 (zeroing), a lane whose mask bit is 0 returns all zeros.
- R7: Mask bit i controls lane i only; with N lanes, mask bits N and above are ignored.
- R8: `out_valid` is high exactly two cycles after `in_valid` was sampled high, and a new operation may be accepted every cycle.
- R9: Operation kind, mask mode and mask are carried with each operation, so back-to-back operations with different settings each produce their own correct result.
- R10: After reset `out_valid` is 0 and `out_data` is 0; while `out_valid` is 0, `out_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present on the inputs |
| in_hi | input | 1 | 1 = add upper product half, 0 = add lower half |
| in_zero | input | 1 | 1 = zeroing mask mode, 0 = merge mode |
| in_mask | input | 8 | Per-lane write mask, bit i for lane i |
| in_acc | input | LANES*64 | Accumulator vector, lane i at bits [64i+63:64i] |
| in_b | input | LANES*64 | First multiplicand vector |
| in_c | input | LANES*64 | Second multiplicand vector |
| out_valid | output | 1 | Result present on out_data |
| out_data | output | LANES*64 | Result vector |

## Verification
The fixed operand set with known high and low answers separates the two product halves. The same operands with garbage in bits [63:52] of the multiplicands show that those bits are dropped, and an all-ones accumulator shows the wrap. A sparse mask applied in both modes, and single-bit masks at the lowest and highest lane, tell merge from zeroing and expose any swap of mask bit and lane. A two-lane instance whose upper mask bits are clear or set shows those bits are ignored. Randomized back-to-back bursts that change kind, mode and mask on every cycle catch any setting that leaves its operation in the pipeline.

// File: rtl/pmac_pkg.sv
package pmac_pkg;
   localparam int unsigned PMAC_LANE_W  = 64;
   localparam int unsigned PMAC_FIELD_W = 52;
   localparam int unsigned PMAC_MASK_W  = 8;

   typedef enum logic { HALF_LO = 1'b0, HALF_HI = 1'b1 } half_e;
   typedef enum logic { MODE_MERGE = 1'b0, MODE_ZERO = 1'b1 } mmode_e;
endpackage

// File: rtl/pmac_mul_stage.sv
module pmac_mul_stage
   import pmac_pkg::*;
#(
   parameter int unsigned LANES   = 8,
   parameter int unsigned LANE_W  = PMAC_LANE_W,
   parameter int unsigned FIELD_W = PMAC_FIELD_W,
   parameter int unsigned MASK_W  = PMAC_MASK_W,
   localparam int unsigned VEC_W  = LANES * LANE_W,
   localparam int unsigned PROD_W = 2 * FIELD_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic                      in_hi,
   input  logic                      in_zero,
   input  logic [MASK_W-1:0]         in_mask,
   input  logic [VEC_W-1:0]          in_acc,
   input  logic [VEC_W-1:0]          in_b,
   input  logic [VEC_W-1:0]          in_c,
   output logic                      s1_valid,
   output half_e                     s1_half,
   output mmode_e                    s1_mode,
   output logic [LANES-1:0]          s1_mask,
   output logic [VEC_W-1:0]          s1_acc,
   output logic [LANES*PROD_W-1:0]   s1_prod
);
   localparam int unsigned DROP_W = LANE_W - FIELD_W;

   // control travels with the operation
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_half  <= HALF_LO;
         s1_mode  <= MODE_MERGE;
         s1_mask  <= '0;
         s1_acc   <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_half <= half_e'(in_hi);
            s1_mode <= mmode_e'(in_zero);
            s1_mask <= in_mask[LANES-1:0];
            s1_acc  <= in_acc;
         end
      end
   end

   generate
      if (LANES < MASK_W) begin : g_mask_spare
         logic spare_mask_unused;
         assign spare_mask_unused = ^in_mask[MASK_W-1:LANES];
      end

      for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
         logic [FIELD_W-1:0] op_b;
         logic [FIELD_W-1:0] op_c;
         logic [PROD_W-1:0]  prod_d;
         logic               drop_unused;

         assign op_b   = in_b[ln*LANE_W +: FIELD_W];
         assign op_c   = in_c[ln*LANE_W +: FIELD_W];
         assign prod_d = PROD_W'(op_b) * PROD_W'(op_c);
         assign drop_unused = ^{in_b[ln*LANE_W+FIELD_W +: DROP_W],
                                in_c[ln*LANE_W+FIELD_W +: DROP_W]};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               s1_prod[ln*PROD_W +: PROD_W] <= '0;
            else if (in_valid)
               s1_prod[ln*PROD_W +: PROD_W] <= prod_d;
         end
      end
   endgenerate
endmodule

// File: rtl/pmac_acc_stage.sv
module pmac_acc_stage
   import pmac_pkg::*;
#(
   parameter int unsigned LANES   = 8,
   parameter int unsigned LANE_W  = PMAC_LANE_W,
   parameter int unsigned FIELD_W = PMAC_FIELD_W,
   localparam int unsigned VEC_W  = LANES * LANE_W,
   localparam int unsigned PROD_W = 2 * FIELD_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      s1_valid,
   input  half_e                     s1_half,
   input  mmode_e                    s1_mode,
   input  logic [LANES-1:0]          s1_mask,
   input  logic [VEC_W-1:0]          s1_acc,
   input  logic [LANES*PROD_W-1:0]   s1_prod,
   output logic                      out_valid,
   output logic [VEC_W-1:0]          out_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= s1_valid;
   end

   generate
      for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
         logic [PROD_W-1:0]  prod;
         logic [FIELD_W-1:0] half_pick;
         logic [LANE_W-1:0]  acc;
         logic [LANE_W-1:0]  sum;
         logic [LANE_W-1:0]  lane_d;

         assign prod      = s1_prod[ln*PROD_W +: PROD_W];
         assign acc       = s1_acc[ln*LANE_W +: LANE_W];
         assign half_pick = (s1_half == HALF_HI) ? prod[PROD_W-1:FIELD_W]
                                                 : prod[FIELD_W-1:0];
         // modulo 2^LANE_W: carry out of the lane is discarded
         assign sum       = acc + LANE_W'(half_pick);

         always_comb begin
            if (s1_mask[ln])                 lane_d = sum;
            else if (s1_mode == MODE_ZERO)   lane_d = '0;
            else                             lane_d = acc;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               out_data[ln*LANE_W +: LANE_W] <= '0;
            else if (s1_valid)
               out_data[ln*LANE_W +: LANE_W] <= lane_d;
         end
      end
   endgenerate
endmodule

// File: rtl/pmac_unit.sv
module pmac_unit
   import pmac_pkg::*;
#(
   parameter int unsigned LANES   = 8,
   parameter int unsigned LANE_W  = PMAC_LANE_W,
   parameter int unsigned FIELD_W = PMAC_FIELD_W,
   parameter int unsigned MASK_W  = PMAC_MASK_W,
   localparam int unsigned VEC_W  = LANES * LANE_W,
   localparam int unsigned PROD_W = 2 * FIELD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic               in_hi,
   input  logic               in_zero,
   input  logic [MASK_W-1:0]  in_mask,
   input  logic [VEC_W-1:0]   in_acc,
   input  logic [VEC_W-1:0]   in_b,
   input  logic [VEC_W-1:0]   in_c,
   output logic               out_valid,
   output logic [VEC_W-1:0]   out_data
);
   generate
      if (!(LANES == 2 || LANES == 4 || LANES == 8)) begin : g_bad_lanes
         $error("pmac_unit: LANES must be 2, 4 or 8");
      end
      if (LANES > MASK_W) begin : g_bad_mask
         $error("pmac_unit: mask narrower than lane count");
      end
      if (FIELD_W >= LANE_W) begin : g_bad_field
         $error("pmac_unit: multiplicand field must be narrower than a lane");
      end
   endgenerate

   logic                    s1_valid;
   half_e                   s1_half;
   mmode_e                  s1_mode;
   logic [LANES-1:0]        s1_mask;
   logic [VEC_W-1:0]        s1_acc;
   logic [LANES*PROD_W-1:0] s1_prod;

   pmac_mul_stage #(
      .LANES(LANES), .LANE_W(LANE_W), .FIELD_W(FIELD_W), .MASK_W(MASK_W)
   ) u_mul (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_hi(in_hi), .in_zero(in_zero),
      .in_mask(in_mask), .in_acc(in_acc), .in_b(in_b), .in_c(in_c),
      .s1_valid(s1_valid), .s1_half(s1_half), .s1_mode(s1_mode),
      .s1_mask(s1_mask), .s1_acc(s1_acc), .s1_prod(s1_prod)
   );

   pmac_acc_stage #(
      .LANES(LANES), .LANE_W(LANE_W), .FIELD_W(FIELD_W)
   ) u_acc (
      .clk(clk), .rst_n(rst_n),
      .s1_valid(s1_valid), .s1_half(s1_half), .s1_mode(s1_mode),
      .s1_mask(s1_mask), .s1_acc(s1_acc), .s1_prod(s1_prod),
      .out_valid(out_valid), .out_data(out_data)
   );
endmodule

// File: rtl/pmac_unit_chk.sv
module pmac_unit_chk #(
   parameter int unsigned LANES  = 8,
   parameter int unsigned LANE_W = 64,
   parameter int unsigned MASK_W = 8,
   localparam int unsigned VEC_W = LANES * LANE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_zero,
   input logic [MASK_W-1:0] in_mask,
   input logic [VEC_W-1:0]  in_acc,
   input logic              out_valid,
   input logic [VEC_W-1:0]  out_data
);
   logic              d1_valid, d2_valid;
   logic              d1_zero,  d2_zero;
   logic [MASK_W-1:0] d1_mask,  d2_mask;
   logic [VEC_W-1:0]  d1_acc,   d2_acc;
   logic              started;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d1_valid <= 1'b0; d2_valid <= 1'b0;
         d1_zero  <= 1'b0; d2_zero  <= 1'b0;
         d1_mask  <= '0;   d2_mask  <= '0;
         d1_acc   <= '0;   d2_acc   <= '0;
         started  <= 1'b0;
      end else begin
         d1_valid <= in_valid; d2_valid <= d1_valid;
         d1_zero  <= in_zero;  d2_zero  <= d1_zero;
         d1_mask  <= in_mask;  d2_mask  <= d1_mask;
         d1_acc   <= in_acc;   d2_acc   <= d1_acc;
         started  <= 1'b1;
      end
   end

   p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == d2_valid);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (started && !out_valid) |-> $stable(out_data));

   generate
      for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
         p_merge_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !d2_zero && !d2_mask[ln])
               |-> out_data[ln*LANE_W +: LANE_W] == d2_acc[ln*LANE_W +: LANE_W]);

         p_zero_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && d2_zero && !d2_mask[ln])
               |-> out_data[ln*LANE_W +: LANE_W] == '0);
      end
   endgenerate
endmodule

bind pmac_unit pmac_unit_chk #(
   .LANES(LANES), .LANE_W(LANE_W), .MASK_W(MASK_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_zero(in_zero),
   .in_mask(in_mask), .in_acc(in_acc), .out_valid(out_valid),
   .out_data(out_data)
);

// File: tb/pmac_unit_tb.sv
module pmac_unit_tb;
   localparam int CLK_PERIOD = 10;
   localparam int LANES = 8;
   localparam int VW = LANES * 64;
   localparam logic [63:0] T_A  = 64'd10 << 40;
   localparam logic [63:0] T_B  = (64'd11 << 40) + 64'd4;
   localparam logic [63:0] T_C  = (64'd12 << 40) + 64'd3;
   localparam logic [63:0] T_HI = 64'd11030549757952;
   localparam logic [63:0] T_LO = 64'd100055558127628;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_hi = 1'b0, in_zero = 1'b0;
   logic [7:0] in_mask = '0;
   logic [VW-1:0] in_acc = '0, in_b = '0, in_c = '0;
   logic out_valid;
   logic [VW-1:0] out_data;

   logic n_valid = 1'b0, n_hi = 1'b0, n_zero = 1'b0;
   logic [7:0] n_mask = '0;
   logic [127:0] n_acc = '0, n_b = '0, n_c = '0;
   logic n_out_valid;
   logic [127:0] n_out_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [VW-1:0] exp_q[$];
   string         tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   pmac_unit #(.LANES(LANES)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hi(in_hi),
      .in_zero(in_zero), .in_mask(in_mask), .in_acc(in_acc), .in_b(in_b),
      .in_c(in_c), .out_valid(out_valid), .out_data(out_data));

   pmac_unit #(.LANES(2)) u_dut_narrow (
      .clk(clk), .rst_n(rst_n), .in_valid(n_valid), .in_hi(n_hi),
      .in_zero(n_zero), .in_mask(n_mask), .in_acc(n_acc), .in_b(n_b),
      .in_c(n_c), .out_valid(n_out_valid), .out_data(n_out_data));

   function automatic logic [63:0] model(input logic hi, input logic zm,
      input logic mb, input logic [63:0] a, input logic [63:0] b, input logic [63:0] c);
      logic [103:0] p;
      logic [51:0]  h;
      p = {52'd0, b[51:0]} * {52'd0, c[51:0]};
      h = hi ? p[103:52] : p[51:0];
      if (mb) return a + {12'd0, h};
      return zm ? 64'd0 : a;
   endfunction

   task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push_op(input logic hi, input logic zm, input logic [7:0] m,
      input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [VW-1:0] c,
      input logic [VW-1:0] e, input string tag);
      in_valid = 1'b1; in_hi = hi; in_zero = zm; in_mask = m;
      in_acc = a; in_b = b; in_c = c;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
   endtask

   task automatic send(input logic hi, input logic zm, input logic [7:0] m,
      input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [VW-1:0] c,
      input string tag);
      logic [VW-1:0] e;
      for (int i = 0; i < LANES; i++)
         e[i*64 +: 64] = model(hi, zm, m[i], a[i*64 +: 64], b[i*64 +: 64], c[i*64 +: 64]);
      push_op(hi, zm, m, a, b, c, e, tag);
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [VW-1:0] rnd_vec();
      logic [VW-1:0] v;
      for (int i = 0; i < LANES; i++) v[i*64 +: 64] = {$urandom, $urandom};
      return v;
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R8 unexpected result actual=%h expected=none", out_data);
         end else begin
            logic [VW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, out_data, e);
         end
      end
   end

   initial begin
      repeat (CLK_PERIOD * 2000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [VW-1:0] va, vb, vc, vz, rb, rc;
      logic [VW-1:0] last;
      va = {LANES{T_A}}; vb = {LANES{T_B}}; vc = {LANES{T_C}};
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10 reset valid", {{(VW-1){1'b0}}, out_valid}, '0);
      check("R10 reset data", out_data, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R2 fixed vector with known answers
      push_op(1'b1, 1'b0, 8'hFF, va, vb, vc, {LANES{T_HI}}, "R1 high half");
      push_op(1'b0, 1'b0, 8'hFF, va, vb, vc, {LANES{T_LO}}, "R2 low half");
      // R3 garbage above bit 51 of multiplicands
      rb = vb; rc = vc;
      for (int i = 0; i < LANES; i++) begin
         rb[i*64+52 +: 12] = 12'hFFF;
         rc[i*64+52 +: 12] = 12'hA5C ^ 12'(i);
      end
      push_op(1'b1, 1'b0, 8'hFF, va, rb, rc, {LANES{T_HI}}, "R3 ignored bits high");
      push_op(1'b0, 1'b1, 8'hFF, va, rb, rc, {LANES{T_LO}}, "R3 ignored bits low");
      // R4 wrap
      vz = {LANES{64'd1}};
      push_op(1'b0, 1'b0, 8'hFF, {LANES{64'hFFFF_FFFF_FFFF_FFFF}}, vz, {LANES{64'd2}},
              {LANES{64'd1}}, "R4 wraps mod 2^64");
      // R5 / R6 sparse mask 0x6D: lanes 0,2,3,5,6 computed
      begin
         logic [VW-1:0] em, ez;
         for (int i = 0; i < LANES; i++) begin
            em[i*64 +: 64] = ((8'h6D >> i) & 8'd1) != 0 ? T_HI : T_A;
            ez[i*64 +: 64] = ((8'h6D >> i) & 8'd1) != 0 ? T_LO : 64'd0;
         end
         push_op(1'b1, 1'b0, 8'h6D, va, vb, vc, em, "R5 merge mask 0x6D");
         push_op(1'b0, 1'b1, 8'h6D, va, vb, vc, ez, "R6 zero mask 0x6D");
      end
      idle(3);

      // R8 latency: lone operation
      send(1'b1, 1'b0, 8'hFF, rnd_vec(), rnd_vec(), rnd_vec(), "R8 lone op data");
      in_valid = 1'b0;
      check("R8 not yet valid", {{(VW-1){1'b0}}, out_valid}, '0);
      @(negedge clk);
      check("R8 valid after two", {{(VW-1){1'b0}}, out_valid}, {{(VW-1){1'b0}}, 1'b1});
      last = out_data;
      idle(4);
      // R10 hold while idle
      check("R10 hold when idle", out_data, last);

      // R7 single-bit masks at each end, both modes
      send(1'b0, 1'b0, 8'h01, rnd_vec(), rnd_vec(), rnd_vec(), "R7 lane0 merge");
      send(1'b1, 1'b1, 8'h80, rnd_vec(), rnd_vec(), rnd_vec(), "R7 lane7 zero");
      send(1'b1, 1'b1, 8'h00, rnd_vec(), rnd_vec(), rnd_vec(), "R6 all masked zero");
      send(1'b0, 1'b0, 8'h00, rnd_vec(), rnd_vec(), rnd_vec(), "R5 all masked merge");
      idle(3);

      // R9 back-to-back with settings changing every cycle
      for (int k = 0; k < 40; k++) begin
         send(1'($urandom), 1'($urandom), 8'($urandom), rnd_vec(), rnd_vec(), rnd_vec(),
              "R9 back-to-back random");
      end
      idle(4);
      check("R8 queue drained", VW'(exp_q.size()), '0);

      // R7 narrow unit: mask bits 2..7 ignored
      n_acc = {2{T_A}}; n_b = {2{T_B}}; n_c = {2{T_C}};
      n_valid = 1'b1; n_hi = 1'b1; n_zero = 1'b1; n_mask = 8'hFC;
      @(negedge clk);
      n_valid = 1'b1; n_hi = 1'b0; n_zero = 1'b0; n_mask = 8'hFE;
      @(negedge clk);
      n_valid = 1'b0;
      checks++;
      if (n_out_data !== 128'd0 || n_out_valid !== 1'b1) begin
         errors++;
         $display("FAIL R7 narrow upper bits zero actual=%h expected=%h", n_out_data, 128'd0);
      end
      @(negedge clk);
      checks++;
      if (n_out_data !== {T_LO, T_A}) begin
         errors++;
         $display("FAIL R7 narrow upper bits merge actual=%h expected=%h", n_out_data, {T_LO, T_A});
      end

      idle(2);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule